// File: doc/BRIEF.md
# Converter Result Bus Interface

This block connects a sampling converter core to a host processor bus. It decides when a conversion starts, shows the host a busy indication and a hold (track/hold) indication, keeps the most recent 11-bit result in an output latch, and returns that result either in one wide access or as two bytes on an 8-bit bus. The 11-bit result holds ten data bits and one overrange flag.

A static mode input chooses how conversions are paced. In the host-paced mode, the host starts each conversion with a write strobe while the chip is selected, and then waits on busy. In the free-running read mode, the core converts back to back once the write strobe has first gone low, and the host only selects and reads. In the byte-read mode of this free-running case, a high-byte read locks the output latch until the matching low-byte read. In the hands-off transfer mode, all host strobes are tied active and conversions repeat from reset onward.

The converter core is modelled as a source with fixed latency. It samples the `ain` word at the edge that starts a conversion and delivers that word `LAT_CYC` cycles later. The bus drivers are modelled as a data word plus an output-enable flag.

Top module: `adc_busif`

## Requirements
- R1: With `wide_bus`=1, a read access returns the whole latched result in one access: `dout[10]` is the overrange flag and `dout[9:0]` are data bits 9..0, equal to the `ain` word sampled when that conversion started.
- R2: With `wide_bus`=0, a read with `hi_sel`=1 returns `{8'b0, ovr, d9, d8}` on `dout[10:0]`. A read with `hi_sel`=0 returns `{3'b0, d7..d0}`.
- R3: `dout_oe` is 1 exactly when `cs_n`=0 and `rd_n`=0. While `dout_oe` is 0, `dout` is all zeros.
- R4: In host-paced mode (`mode_sel`=0), a falling edge on `wr_n` while `cs_n`=0 starts a conversion, and `hold` is high after that clock edge. A falling edge on `wr_n` while `cs_n`=1 starts nothing.
- R5: In host-paced mode, `busy` is low for exactly `LAT_CYC` cycles after the start edge. It rises in the same cycle in which the new result is in the output latch.
- R6: In host-paced mode, a write strobe during a conversion is ignored. The busy-low time does not change, no further conversion follows, and the result is the first sample.
- R7: In host-paced mode and in hands-off mode (`mode_sel`=2), the two bytes can be read in either order. The next conversion still updates the latch.
- R8: In free-running read mode (`mode_sel`=1), no conversion starts until `wr_n` is first seen low. After that, conversions repeat every `LAT_CYC`+1 cycles, with `hold` low for one cycle between them.
- R9: In free-running read mode with the 8-bit bus, a high-byte read locks the latch until a low-byte read. A result that completes while the latch is locked is discarded. Reading the high byte and then the low byte loses nothing.
- R10: In free-running and hands-off modes, `busy` is 0 during any read access (`cs_n`=0, `rd_n`=0) and 1 otherwise.
- R11: In hands-off mode, with `cs_n`, `rd_n` and `wr_n` held low, conversions start from the first edge after reset, and each result reaches the latch.
- R12: After reset, `hold`=0, the latch holds zero, and in host-paced mode `busy`=1 and no conversion runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | 2 | 0 host-paced, 1 free-running read, 2 hands-off; static after reset |
| wide_bus | input | 1 | 1 full-width reads, 0 byte reads; static after reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| hi_sel | input | 1 | Byte select for 8-bit reads, 1 high byte |
| ain | input | 11 | Core input word sampled at conversion start (overrange in bit 10) |
| busy | output | 1 | Low while converting (host-paced) or while reading (other modes) |
| hold | output | 1 | High while a conversion is in progress |
| dout | output | 11 | Read data, zero when not enabled |
| dout_oe | output | 1 | Read data drive enable |

## Verification
A conversion counter that is off by one shows up within one conversion. The busy-low window is one cycle too long or too short, and in the free-running modes the spacing between `hold` falls is wrong, so the first period already exposes it. A lock flag that is set when it should be clear, or the reverse, is seen on the next read after the following `hold` fall: that read returns the stale word when it should return the fresh one, or the fresh word when it should return the stale one. A wrong byte-select path or a wrong enable path shows on the very access that uses it, as misplaced bits or as nonzero data while the enable is off.

// File: rtl/adc_busif_pkg.sv
// Shared types for the converter bus interface.
// Assumes the mode input is held static after reset.
package adc_busif_pkg;

    // Conversion pacing modes; code 3 is treated like hands-off mode
    typedef enum logic [1:0] {
        MODE_HOST = 2'd0,
        MODE_FREE = 2'd1,
        MODE_AUTO = 2'd2,
        MODE_RSVD = 2'd3
    } pace_mode_e;

endpackage

// File: rtl/adc_busif_conv.sv
// Conversion sequencer with a fixed-latency core model.
// Decides when a conversion starts from the pacing mode and the strobes,
// samples the input word at the start edge and flags completion.
// Assumes LAT_CYC >= 1 and a static mode.
module adc_busif_conv
    import adc_busif_pkg::*;
#(
    parameter int LAT_CYC = 50,
    parameter int RES_W   = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pace_mode_e       mode,
    input  logic             cs_n,
    input  logic             wr_n,
    input  logic [RES_W-1:0] ain,
    output logic             hold,
    output logic             done,
    output logic [RES_W-1:0] sample
);
    localparam int CW = $clog2(LAT_CYC + 1);

    logic          active;
    logic [CW-1:0] cnt;
    logic          wr_q;
    logic          armed;
    logic          start_ok;
    logic          start_go;

    // Start condition for each pacing mode
    always_comb begin
        case (mode)
            MODE_HOST: start_ok = !cs_n && wr_q && !wr_n;
            MODE_FREE: start_ok = armed || !wr_n;
            default:   start_ok = 1'b1;
        endcase
    end

    assign start_go = !active && start_ok;
    assign done     = active && (cnt == '0);
    assign hold     = active;

    // Write strobe history for falling-edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) wr_q <= 1'b1;
        else        wr_q <= wr_n;
    end

    // Conversion state: start, latency countdown, completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
            armed  <= 1'b0;
            sample <= '0;
        end else if (start_go) begin
            active <= 1'b1;
            cnt    <= CW'(LAT_CYC - 1);
            armed  <= 1'b1;
            sample <= ain;
        end else if (active) begin
            if (cnt == '0) active <= 1'b0;
            else           cnt    <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/adc_busif_latch.sv
// Output result latch with the byte-order lock.
// In free-running mode on an 8-bit bus, a high-byte read locks the latch
// until a low-byte read; results that finish while it is locked are dropped.
// Assumes mode and bus width are static.
module adc_busif_latch
    import adc_busif_pkg::*;
#(
    parameter int RES_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pace_mode_e       mode,
    input  logic             wide,
    input  logic             hi_sel,
    input  logic             rd_acc,
    input  logic             done,
    input  logic [RES_W-1:0] sample,
    output logic [RES_W-1:0] res
);
    logic lock_q;
    logic free_run;
    logic hi_rd;
    logic lo_rd;
    logic blocked;

    assign free_run = (mode == MODE_FREE);
    assign hi_rd    = rd_acc && !wide && hi_sel;
    assign lo_rd    = rd_acc && !wide && !hi_sel;
    assign blocked  = lock_q || (free_run && hi_rd);

    // Lock flag: set by a high-byte read, cleared by a low-byte read
    always_ff @(posedge clk) begin
        if (!rst_n)                lock_q <= 1'b0;
        else if (free_run && hi_rd) lock_q <= 1'b1;
        else if (lo_rd || !free_run) lock_q <= 1'b0;
    end

    // Result capture when a conversion completes and the latch is open
    always_ff @(posedge clk) begin
        if (!rst_n)                res <= '0;
        else if (done && !blocked) res <= sample;
    end
endmodule

// File: rtl/adc_busif_bus.sv
// Host-side read path and status.
// Drives the read word (wide or one byte), its enable and the busy flag.
// Assumes RES_W > 8 so the high byte holds the bits above bit 7.
module adc_busif_bus
    import adc_busif_pkg::*;
#(
    parameter int RES_W = 11
) (
    input  pace_mode_e       mode,
    input  logic             wide,
    input  logic             hi_sel,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             hold,
    input  logic [RES_W-1:0] res,
    output logic             rd_acc,
    output logic [RES_W-1:0] dout,
    output logic             dout_oe,
    output logic             busy
);
    assign rd_acc  = !cs_n && !rd_n;
    assign dout_oe = rd_acc;

    // Read word selection; zero whenever the drivers are off
    always_comb begin
        dout = '0;
        if (rd_acc) begin
            if (wide)        dout = res;
            else if (hi_sel) dout = RES_W'(res[RES_W-1:8]);
            else             dout = RES_W'(res[7:0]);
        end
    end

    // Busy: conversion status when host-paced, read status otherwise
    always_comb begin
        if (mode == MODE_HOST) busy = !hold;
        else                   busy = !rd_acc;
    end
endmodule

// File: rtl/adc_busif.sv
// Top of the converter bus interface: sequencer, result latch, read path.
// Assumes mode_sel and wide_bus are static after reset.
module adc_busif
    import adc_busif_pkg::*;
#(
    parameter int DATA_W  = 10,
    parameter int LAT_CYC = 50,
    localparam int RES_W  = DATA_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_sel,
    input  logic             wide_bus,
    input  logic             cs_n,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic             hi_sel,
    input  logic [RES_W-1:0] ain,
    output logic             busy,
    output logic             hold,
    output logic [RES_W-1:0] dout,
    output logic             dout_oe
);
    pace_mode_e       mode;
    logic             done;
    logic             rd_acc;
    logic [RES_W-1:0] sample;
    logic [RES_W-1:0] res;

    assign mode = pace_mode_e'(mode_sel);

    adc_busif_conv #(.LAT_CYC(LAT_CYC), .RES_W(RES_W)) conv_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .cs_n(cs_n), .wr_n(wr_n),
        .ain(ain), .hold(hold), .done(done), .sample(sample)
    );

    adc_busif_latch #(.RES_W(RES_W)) latch_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .wide(wide_bus),
        .hi_sel(hi_sel), .rd_acc(rd_acc), .done(done), .sample(sample),
        .res(res)
    );

    adc_busif_bus #(.RES_W(RES_W)) bus_i (
        .mode(mode), .wide(wide_bus), .hi_sel(hi_sel), .cs_n(cs_n),
        .rd_n(rd_n), .hold(hold), .res(res), .rd_acc(rd_acc), .dout(dout),
        .dout_oe(dout_oe), .busy(busy)
    );
endmodule

// File: rtl/adc_busif_chk.sv
// Port-level property checker for adc_busif, attached with bind.
module adc_busif_chk #(
    parameter int LAT_CYC = 50,
    parameter int RES_W   = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode_sel,
    input logic             cs_n,
    input logic             wr_n,
    input logic             rd_n,
    input logic             busy,
    input logic             hold,
    input logic [RES_W-1:0] dout,
    input logic             dout_oe
);
    localparam int CW = $clog2(LAT_CYC + 2);
    localparam logic [CW-1:0] HMAX = CW'(LAT_CYC + 1);

    logic [CW-1:0] hcnt;

    // Length of the current hold-high stretch, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)     hcnt <= '0;
        else if (!hold) hcnt <= '0;
        else if (hcnt != HMAX) hcnt <= hcnt + 1'b1;
    end

    AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> (dout == '0)); // R3

    AST_HOLD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold) |-> (hcnt == CW'(LAT_CYC))); // R5

    AST_HOST_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'd0) |-> (busy == !hold)); // R5

    AST_HOST_START: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'd0 && $rose(hold)) |-> (!$past(cs_n) && !$past(wr_n))); // R4

    AST_READ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel != 2'd0 && !cs_n && !rd_n) |-> !busy); // R10
endmodule

bind adc_busif adc_busif_chk #(.LAT_CYC(LAT_CYC), .RES_W(RES_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n), .wr_n(wr_n),
    .rd_n(rd_n), .busy(busy), .hold(hold), .dout(dout), .dout_oe(dout_oe)
);

// File: tb/adc_busif_tb_top.sv
// Directed bench for adc_busif: one task per scenario.
module adc_busif_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LAT = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_sel = 2'd0;
    logic        wide_bus = 1'b1;
    logic        cs_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        hi_sel = 1'b0;
    logic [10:0] ain = 11'h5A3;
    logic        busy;
    logic        hold;
    logic [10:0] dout;
    logic        dout_oe;

    int          total = 0;
    int          bad = 0;
    logic [10:0] last_cap = '0;
    logic        hold_prev = 1'b0;

    adc_busif #(.LAT_CYC(LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .wide_bus(wide_bus),
        .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .hi_sel(hi_sel), .ain(ain),
        .busy(busy), .hold(hold), .dout(dout), .dout_oe(dout_oe)
    );

    initial forever #(CLK_PERIOD / 2) clk = ~clk;

    // Counting input pattern: record the sampled word, advance after each start
    initial forever begin
        @(negedge clk);
        if (hold && !hold_prev) begin
            last_cap = ain;
            ain      = ain + 11'd1;
        end
        hold_prev = hold;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] m, input logic w, input logic tied);
        @(negedge clk);
        rst_n = 1'b0; mode_sel = m; wide_bus = w; hi_sel = 1'b0;
        cs_n = !tied; rd_n = !tied; wr_n = !tied;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic rd(input logic hi, output logic [10:0] v, output logic b);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; hi_sel = hi;
        #(CLK_PERIOD / 4);
        v = dout; b = busy;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic host_start();
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (hold);
    endtask

    task automatic wait_fall();
        logic prv;
        prv = hold;
        forever begin
            @(negedge clk);
            if (prv && !hold) break;
            prv = hold;
        end
    endtask

    task automatic t_reset();
        logic [10:0] v; logic b;
        do_reset(2'd0, 1'b1, 1'b0);
        @(negedge clk);
        chk("R12", "hold after reset", hold, 0);
        chk("R12", "busy after reset", busy, 1);
        chk("R3", "oe idle", dout_oe, 0);
        rd(1'b0, v, b);
        chk("R12", "latch after reset", v, 0);
        repeat (5) @(negedge clk);
        chk("R12", "no self start", hold, 0);
    endtask

    task automatic t_host_conv();
        logic [10:0] v; logic b; int n;
        do_reset(2'd0, 1'b1, 1'b0);
        host_start();
        chk("R4", "hold after start", hold, 1);
        n = 0;
        while (!busy) begin n++; @(negedge clk); end
        chk("R5", "busy low cycles", n, LAT);
        rd(1'b0, v, b);
        chk("R1", "wide result", v, last_cap);
    endtask

    task automatic t_host_nocs();
        do_reset(2'd0, 1'b1, 1'b0);
        @(negedge clk); wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R4", "no start without select", hold, 0);
        chk("R4", "busy stays high", busy, 1);
    endtask

    task automatic t_host_ignore();
        logic [10:0] v; logic [10:0] first; logic b; int n;
        do_reset(2'd0, 1'b1, 1'b0);
        host_start();
        n = 0;
        while (!busy) begin
            n++;
            if (n == 3) begin cs_n = 1'b0; wr_n = 1'b0; end
            if (n == 4) begin cs_n = 1'b1; wr_n = 1'b1; end
            @(negedge clk);
        end
        cs_n = 1'b1; wr_n = 1'b1;
        first = last_cap;
        chk("R6", "busy low with extra strobe", n, LAT);
        repeat (3) @(negedge clk);
        chk("R6", "no follow-on conversion", hold, 0);
        rd(1'b0, v, b);
        chk("R6", "first sample kept", v, first);
    endtask

    task automatic t_oe();
        for (int c = 0; c < 2; c++) begin
            for (int r = 0; r < 2; r++) begin
                @(negedge clk);
                cs_n = c[0]; rd_n = r[0]; hi_sel = 1'b0;
                #(CLK_PERIOD / 4);
                chk("R3", "oe for strobes", dout_oe, (c == 0 && r == 0));
                if (!(c == 0 && r == 0)) chk("R3", "data off", dout, 0);
            end
        end
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic t_host_bytes();
        logic [10:0] v; logic [10:0] e; logic b;
        do_reset(2'd0, 1'b0, 1'b0);
        host_start(); wait_idle();
        e = last_cap;
        rd(1'b0, v, b); chk("R2", "low byte", v, {3'b0, e[7:0]});
        rd(1'b1, v, b); chk("R2", "high byte", v, {8'b0, e[10:8]});
        host_start(); wait_idle();
        e = last_cap;
        rd(1'b1, v, b); chk("R7", "host high after low-first", v, {8'b0, e[10:8]});
        rd(1'b0, v, b); chk("R7", "host low after low-first", v, {3'b0, e[7:0]});
    endtask

    task automatic t_free_start();
        int n;
        do_reset(2'd1, 1'b0, 1'b0);
        repeat (6) @(negedge clk);
        chk("R8", "waits for first strobe", hold, 0);
        chk("R10", "busy high when idle", busy, 1);
        wr_n = 1'b0;
        @(negedge clk);
        chk("R8", "hold follows strobe", hold, 1);
        wait_fall();
        @(negedge clk);
        chk("R8", "one idle cycle", hold, 1);
        n = 1;
        while (hold) begin n++; @(negedge clk); end
        chk("R8", "period", n, LAT + 1);
    endtask

    task automatic t_free_order();
        logic [10:0] v; logic [10:0] e; logic b;
        wait_fall();
        e = last_cap;
        rd(1'b1, v, b);
        chk("R10", "busy in read", b, 0);
        chk("R9", "high first", v, {8'b0, e[10:8]});
        rd(1'b0, v, b); chk("R9", "low second", v, {3'b0, e[7:0]});
        wait_fall();
        e = last_cap;
        rd(1'b1, v, b); chk("R9", "next high", v, {8'b0, e[10:8]});
        rd(1'b0, v, b); chk("R9", "next low updated", v, {3'b0, e[7:0]});
    endtask

    task automatic t_free_reverse();
        logic [10:0] v; logic [10:0] e; logic b;
        wait_fall();
        e = last_cap;
        rd(1'b0, v, b); chk("R9", "rev low", v, {3'b0, e[7:0]});
        rd(1'b1, v, b); chk("R9", "rev high", v, {8'b0, e[10:8]});
        wait_fall();
        rd(1'b0, v, b); chk("R9", "locked result kept", v, {3'b0, e[7:0]});
        wait_fall();
        e = last_cap;
        rd(1'b1, v, b); chk("R9", "unlocked high", v, {8'b0, e[10:8]});
        rd(1'b0, v, b); chk("R9", "unlocked low", v, {3'b0, e[7:0]});
    endtask

    task automatic t_auto();
        logic [10:0] e; logic [10:0] v;
        do_reset(2'd2, 1'b0, 1'b1);
        @(negedge clk);
        chk("R11", "starts after reset", hold, 1);
        for (int k = 0; k < 2; k++) begin
            wait_fall();
            e = last_cap;
            @(negedge clk); hi_sel = k[0];
            #(CLK_PERIOD / 4); v = dout;
            chk("R10", "busy low hands-off", busy, 0);
            chk(k == 0 ? "R11" : "R7", "first byte",
                v, k[0] ? {8'b0, e[10:8]} : {3'b0, e[7:0]});
            @(negedge clk); hi_sel = !k[0];
            #(CLK_PERIOD / 4); v = dout;
            chk("R7", "second byte",
                v, k[0] ? {3'b0, e[7:0]} : {8'b0, e[10:8]});
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_host_conv();
        t_oe();
        t_host_nocs();
        t_host_ignore();
        t_host_bytes();
        t_free_start();
        t_free_order();
        t_free_reverse();
        t_auto();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule